// File: doc/BRIEF.md
# Automatic Buffered Serial Transfer Engine

This block is a synchronous three-wire serial master that sends and receives a whole block of bytes on its own. A 32-entry byte buffer sits inside the block. Software fills the buffer with outgoing bytes, programs a last-offset register, and pulses a start input. The engine then works through the buffer from offset 0 without further help. For each slot it fetches the byte, shifts it out MSB first while shifting a byte in, and stores the incoming byte over the outgoing one in the same slot. It then advances its slot counter.

The controller is a five-state machine:
- `ST_IDLE` waits for start.
- `ST_FETCH` reads the slot at the counter and loads the shifter.
- `ST_SHIFT` waits for the shifter to report a finished byte.
- `ST_STORE` writes the received byte back and increments the counter.
- `ST_FINISH` raises the completion flag, clears the counter and drops busy.

The transitions are:
- IDLE→FETCH when start is seen.
- FETCH→SHIFT unconditionally.
- SHIFT→STORE when the byte is done.
- STORE→FETCH when the slot just stored is not the last one.
- STORE→FINISH when the slot just stored equals the last-offset register.
- FINISH→IDLE unconditionally.

The serial clock idles high. Output data changes on its falling edge and input data is sampled on its rising edge. A single active-low select strobe is low for the whole block.

Top module: `ase_top`

## Requirements
- R1: After reset, `busy`=0, `irq_flag`=0, `xfer_cnt`=0, `sclk`=1 and `cs_n`=1.
- R2: Each byte takes exactly 8 serial clock cycles, MSB first. `mosi` changes only when `sclk` falls, `miso` is sampled when `sclk` rises, and `sclk` is high whenever no byte is shifting.
- R3: The first byte sent is buffer offset 0, and the bytes go out in rising offset order.
- R4: When a byte completes, the received byte replaces the content of the offset that supplied the transmitted byte. Offsets beyond the last-offset register are untouched.
- R5: `xfer_cnt` rises by one after each completed byte. A block with last-offset value P moves exactly P+1 bytes (8·(P+1) rising `sclk` edges).
- R6: On the edge that ends a block, `irq_flag` becomes 1, and `busy` and `xfer_cnt` both become 0.
- R7: A `start` pulse while `busy`=1 is ignored: the running block keeps its length and no second block follows.
- R8: While `busy`=1, CPU writes to the buffer (`cpu_we`) and to the last-offset register (`end_ptr_we`) are ignored.
- R9: `irq_flag` stays 1 until an `irq_clr` pulse clears it on the next edge. If a completion and `irq_clr` fall in the same cycle, the completion wins and the flag ends up 1.
- R10: After a byte's write-back, the next byte begins automatically with no software action, and `busy` and `cs_n`=0 hold for the whole block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse to begin a block transfer |
| end_ptr_we | input | 1 | Write strobe for the last-offset register |
| end_ptr_in | input | 5 | Offset of the last byte to transfer |
| irq_clr | input | 1 | Write-one-to-clear strobe for the completion flag |
| cpu_we | input | 1 | CPU buffer write strobe |
| cpu_addr | input | 5 | CPU buffer offset |
| cpu_wdata | input | 8 | CPU buffer write data |
| cpu_rdata | output | 8 | Buffer read data (engine slot while busy) |
| busy | output | 1 | Block transfer in progress |
| irq_flag | output | 1 | Block completion flag |
| xfer_cnt | output | 5 | Current slot counter |
| sclk | output | 1 | Serial clock, idle high |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select, low while busy |

## Verification
The completion flag can be set and cleared in the same cycle: the engine finishes a block on the very edge at which software pulses the clear strobe. The bench provokes this by holding `irq_clr` high for the whole transfer, so the strobe is certain to overlap the finishing edge. It releases the strobe at the first falling clock edge where `busy` reads 0, and then judges that the flag reads 1, because the set must have won. A later lone clear pulse must bring the flag back to 0.

// File: rtl/ase_pkg.sv
package ase_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_SHIFT  = 3'd2,
        ST_STORE  = 3'd3,
        ST_FINISH = 3'd4
    } ase_state_t;

endpackage

// File: rtl/ase_buffer.sv
module ase_buffer #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eng_own,
    input  logic              cpu_we,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              eng_we,
    input  logic [AW-1:0]     eng_addr,
    input  logic [DATA_W-1:0] eng_wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     port_addr;
    logic [DATA_W-1:0] port_wdata;
    logic              port_we;
    logic              cpu_we_g;

    // single port: the engine owns it while a block runs
    assign cpu_we_g   = cpu_we && !eng_own;
    assign port_addr  = eng_own ? eng_addr  : cpu_addr;
    assign port_wdata = eng_own ? eng_wdata : cpu_wdata;
    assign port_we    = eng_own ? eng_we    : cpu_we_g;

    always_ff @(posedge clk) begin
        if (port_we) begin
            mem[port_addr] <= port_wdata;
        end
    end

    assign rdata = mem[port_addr];

    assert_single_writer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_we_g, eng_we}));

endmodule

// File: rtl/ase_shifter.sv
module ase_shifter #(
    parameter int DATA_W   = 8,
    parameter int HALF_CYC = 2,
    localparam int BW      = $clog2(DATA_W),
    localparam int TW      = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_byte,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              active,
    output logic              byte_done,
    output logic [DATA_W-1:0] rx_byte
);

    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;
    logic [BW-1:0]     bit_idx;
    logic [TW-1:0]     tick_cnt;
    logic              sclk_q;
    logic              mosi_q;
    logic              done_q;
    logic              tick_end;

    assign tick_end = (tick_cnt == TW'(HALF_CYC - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active   <= 1'b0;
            sclk_q   <= 1'b1;
            mosi_q   <= 1'b0;
            tx_sr    <= '0;
            rx_sr    <= '0;
            bit_idx  <= '0;
            tick_cnt <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (load && !active) begin
                active   <= 1'b1;
                tx_sr    <= load_byte;
                bit_idx  <= '0;
                tick_cnt <= '0;
                sclk_q   <= 1'b1;
            end else if (active) begin
                if (tick_end) begin
                    tick_cnt <= '0;
                    sclk_q   <= ~sclk_q;
                    if (sclk_q) begin
                        // falling edge: present next bit, MSB first
                        mosi_q <= tx_sr[DATA_W-1];
                        tx_sr  <= {tx_sr[DATA_W-2:0], 1'b0};
                    end else begin
                        // rising edge: capture input bit
                        rx_sr   <= {rx_sr[DATA_W-2:0], miso};
                        bit_idx <= bit_idx + 1'b1;
                        if (bit_idx == BW'(DATA_W - 1)) begin
                            active <= 1'b0;
                            done_q <= 1'b1;
                        end
                    end
                end else begin
                    tick_cnt <= tick_cnt + 1'b1;
                end
            end
        end
    end

    assign sclk      = sclk_q;
    assign mosi      = mosi_q;
    assign byte_done = done_q;
    assign rx_byte   = rx_sr;

    assert_idle_clock_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> sclk_q);

    assert_mosi_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mosi_q) |-> $fell(sclk_q));

    assert_no_load_while_active_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !active);

endmodule

// File: rtl/ase_ctrl.sv
module ase_ctrl
    import ase_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          end_ptr_we,
    input  logic [AW-1:0] end_ptr_in,
    input  logic          irq_clr,
    input  logic          byte_done,
    output logic          busy,
    output logic          irq_flag,
    output logic [AW-1:0] cnt,
    output logic          shift_load,
    output logic          buf_we
);

    ase_state_t    st, nxt;
    logic [AW-1:0] end_ptr;
    logic          last_slot;

    assign last_slot = (cnt == end_ptr);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:   if (start) nxt = ST_FETCH;
            ST_FETCH:  nxt = ST_SHIFT;
            ST_SHIFT:  if (byte_done) nxt = ST_STORE;
            ST_STORE:  nxt = last_slot ? ST_FINISH : ST_FETCH;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        busy       = 1'b1;
        shift_load = 1'b0;
        buf_we     = 1'b0;
        unique case (st)
            ST_IDLE:   busy = 1'b0;
            ST_FETCH:  shift_load = 1'b1;
            ST_SHIFT:  busy = 1'b1;
            ST_STORE:  buf_we = 1'b1;
            ST_FINISH: busy = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    // counter, last-offset register, completion flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            end_ptr  <= '0;
            irq_flag <= 1'b0;
        end else begin
            if (end_ptr_we && st == ST_IDLE) begin
                end_ptr <= end_ptr_in;
            end
            if (st == ST_STORE) begin
                cnt <= cnt + 1'b1;
            end else if (st == ST_FINISH) begin
                cnt <= '0;
            end
            if (st == ST_FINISH) begin
                irq_flag <= 1'b1;
            end else if (irq_clr) begin
                irq_flag <= 1'b0;
            end
        end
    end

    assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (irq_flag && cnt == '0));

    assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && st != ST_FINISH) |=> busy);

    assert_clear_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && st != ST_FINISH) |=> !irq_flag);

    assert_byte_done_in_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> st == ST_SHIFT);

endmodule

// File: rtl/ase_top.sv
module ase_top #(
    parameter int DATA_W   = 8,
    parameter int DEPTH    = 32,
    parameter int HALF_CYC = 2,
    localparam int AW      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              end_ptr_we,
    input  logic [AW-1:0]     end_ptr_in,
    input  logic              irq_clr,
    input  logic              cpu_we,
    input  logic [AW-1:0]     cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              busy,
    output logic              irq_flag,
    output logic [AW-1:0]     xfer_cnt,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);

    logic              shift_load;
    logic              buf_we;
    logic              byte_done;
    logic              shift_active;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] buf_rdata;

    ase_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .end_ptr_we (end_ptr_we),
        .end_ptr_in (end_ptr_in),
        .irq_clr    (irq_clr),
        .byte_done  (byte_done),
        .busy       (busy),
        .irq_flag   (irq_flag),
        .cnt        (xfer_cnt),
        .shift_load (shift_load),
        .buf_we     (buf_we)
    );

    ase_buffer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .eng_own   (busy),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .cpu_wdata (cpu_wdata),
        .eng_we    (buf_we),
        .eng_addr  (xfer_cnt),
        .eng_wdata (rx_byte),
        .rdata     (buf_rdata)
    );

    ase_shifter #(.DATA_W(DATA_W), .HALF_CYC(HALF_CYC)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (shift_load),
        .load_byte (buf_rdata),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .active    (shift_active),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

    assign cpu_rdata = buf_rdata;
    assign cs_n      = ~busy;

    assert_clock_only_when_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        shift_active |-> !cs_n);

endmodule

// File: tb/tb_ase_top.sv
module tb_ase_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 5;
    localparam int DEPTH = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic end_ptr_we = 1'b0;
    logic [AW-1:0] end_ptr_in = '0;
    logic irq_clr = 1'b0;
    logic cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic busy, irq_flag, sclk, mosi, cs_n;
    logic [AW-1:0] xfer_cnt;
    logic miso;
    logic invert_mode = 1'b0;

    int n_tests = 0;
    int n_fail = 0;
    int cycles = 0;
    int rise_cnt = 0;
    int inc_cnt = 0;
    logic [AW-1:0] prev_cnt = '0;
    logic [7:0] cap_sr = '0;
    logic [7:0] cap_bytes [DEPTH];
    logic [7:0] orig [DEPTH];

    assign miso = invert_mode ? ~mosi : mosi;

    always #(CLK_PERIOD/2) clk = ~clk;

    ase_top dut (
        .clk(clk), .rst_n(rst_n), .start(start), .end_ptr_we(end_ptr_we),
        .end_ptr_in(end_ptr_in), .irq_clr(irq_clr), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .busy(busy), .irq_flag(irq_flag), .xfer_cnt(xfer_cnt), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // observe the serial stream independently
    always @(posedge sclk) begin
        if (rst_n) begin
            cap_sr = {cap_sr[6:0], mosi};
            rise_cnt = rise_cnt + 1;
            if (rise_cnt % 8 == 0 && rise_cnt / 8 <= DEPTH)
                cap_bytes[rise_cnt/8 - 1] = cap_sr;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && xfer_cnt != prev_cnt && xfer_cnt == prev_cnt + 1'b1)
            inc_cnt <= inc_cnt + 1;
        prev_cnt <= xfer_cnt;
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_buf(input int a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = AW'(a); cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic read_buf(input int a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = AW'(a);
        #1 d = cpu_rdata;
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < DEPTH; i++) begin
            orig[i] = 8'((i * 37 + seed * 11 + 8'h5A) ^ (i << 3));
            write_buf(i, orig[i]);
        end
    endtask

    task automatic set_ptr(input int p);
        @(negedge clk);
        end_ptr_in = AW'(p); end_ptr_we = 1'b1;
        @(negedge clk);
        end_ptr_we = 1'b0;
    endtask

    task automatic pulse_start;
        @(negedge clk);
        rise_cnt = 0; inc_cnt = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle;
        while (busy && cycles < 150000) @(negedge clk);
    endtask

    task automatic clear_irq;
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
    endtask

    task automatic t_reset_state;
        check(busy == 0, "R1 busy", busy, 0);
        check(irq_flag == 0, "R1 irq_flag", irq_flag, 0);
        check(xfer_cnt == 0, "R1 xfer_cnt", xfer_cnt, 0);
        check(sclk == 1 && cs_n == 1, "R1 sclk/cs_n", {sclk, cs_n}, 3);
    endtask

    task automatic t_loopback(input int p);
        logic [7:0] d;
        logic seen_early_irq;
        fill(p);
        set_ptr(p);
        invert_mode = 1'b0;
        pulse_start;
        seen_early_irq = 1'b0;
        check(busy == 1 && cs_n == 0, "R10 busy/cs_n during block", {busy, cs_n}, 2);
        while (busy && cycles < 150000) begin
            if (irq_flag) seen_early_irq = 1'b1;
            if (!busy || cs_n) seen_early_irq = 1'b1;
            @(negedge clk);
        end
        check(!seen_early_irq, "R10 continuous block, no early flag", seen_early_irq, 0);
        check(irq_flag == 1, "R6 flag set at end", irq_flag, 1);
        check(xfer_cnt == 0, "R6 counter cleared", xfer_cnt, 0);
        check(rise_cnt == 8 * (p + 1), "R5 sclk rising edges", rise_cnt, 8 * (p + 1));
        check(inc_cnt == p + 1, "R5 counter increments", inc_cnt, p + 1);
        for (int i = 0; i <= p; i++)
            check(cap_bytes[i] == orig[i], "R3 R2 stream order MSB first", cap_bytes[i], orig[i]);
        for (int i = 0; i < DEPTH; i++) begin
            read_buf(i, d);
            check(d == orig[i], "R4 loopback buffer unchanged", d, orig[i]);
        end
        check(sclk == 1, "R2 sclk idle high after block", sclk, 1);
        clear_irq;
    endtask

    task automatic t_invert(input int p);
        logic [7:0] d;
        fill(p + 3);
        set_ptr(p);
        invert_mode = 1'b1;
        pulse_start;
        wait_idle;
        invert_mode = 1'b0;
        check(rise_cnt == 8 * (p + 1), "R5 byte count inverted run", rise_cnt, 8 * (p + 1));
        for (int i = 0; i < DEPTH; i++) begin
            read_buf(i, d);
            if (i <= p) check(d == ~orig[i], "R4 received byte written back", d, ~orig[i]);
            else        check(d == orig[i], "R4 slot beyond end untouched", d, orig[i]);
        end
        clear_irq;
    endtask

    task automatic t_start_while_busy;
        fill(7);
        set_ptr(3);
        pulse_start;
        while (xfer_cnt != 2 && busy && cycles < 150000) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle;
        check(rise_cnt == 32, "R7 block length unchanged by start", rise_cnt, 32);
        repeat (40) @(negedge clk);
        check(busy == 0 && rise_cnt == 32, "R7 no second block", rise_cnt, 32);
        clear_irq;
    endtask

    task automatic t_cpu_write_blocked;
        logic [7:0] d;
        fill(9);
        set_ptr(2);
        pulse_start;
        @(negedge clk);
        cpu_addr = AW'(20); cpu_wdata = ~orig[20]; cpu_we = 1'b1;
        end_ptr_in = AW'(31); end_ptr_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0; end_ptr_we = 1'b0;
        wait_idle;
        check(rise_cnt == 24, "R8 last-offset write ignored while busy", rise_cnt, 24);
        read_buf(20, d);
        check(d == orig[20], "R8 buffer write ignored while busy", d, orig[20]);
        clear_irq;
    endtask

    task automatic t_irq_collide;
        fill(1);
        set_ptr(1);
        @(negedge clk);
        irq_clr = 1'b1;
        pulse_start;
        wait_idle;
        irq_clr = 1'b0;
        check(irq_flag == 1, "R9 set wins over same-cycle clear", irq_flag, 1);
        repeat (5) @(negedge clk);
        check(irq_flag == 1, "R9 flag holds until cleared", irq_flag, 1);
        clear_irq;
        check(irq_flag == 0, "R9 write-one clear", irq_flag, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset_state;
        t_loopback(5);
        t_loopback(0);
        t_loopback(31);
        t_invert(2);
        t_start_while_busy;
        t_cpu_write_blocked;
        t_irq_collide;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wait (cycles >= 160000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, 160000);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule